// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One down-counting timer channel, `CW` bits wide (16 by default). It runs from the system clock and moves forward only on cycles where the one-cycle `tick` enable is high. Software-side logic elsewhere supplies a mode code, a new initial count and a `load` strobe. The channel produces one output waveform and exposes the live count and a registered copy of its gate input. Counting is binary only.

The channel has six operating behaviours. Two are one-shot output levels: terminal-count interrupt and gate-triggered one-shot. Two repeat: rate pulse and square wave. Two produce a single strobe: software-started and gate-started. The gate input acts differently in each mode. In some modes a low gate freezes counting. In others a rising edge on the gate restarts the period from the initial count.

Control is a three-state machine:
- RUN: counting.
- LOAD: a new count is staged and waits for the next tick.
- ARMED: the gate-triggered one-shot waits for its gate edge.

Transitions:
- STAGE: any state moves to LOAD on `load`.
- COMMIT: LOAD moves to RUN on `tick`. If the staged mode is the one-shot, COMMIT goes to ARMED instead.
- FIRE: ARMED moves to RUN on a tick with a captured gate rising edge.
- RETRIGGER: RUN stays in RUN and restarts on a tick with a captured gate edge, in the modes that allow it.

Top module: `interval_counter_channel`

## Requirements
- R1: After reset the channel is in mode 3 with an initial count of 65536. `count_o` reads 0 and `out_o` is high. Two ticks later, with the gate high, `count_o` reads 65534.
- R2: A loaded count of 0 means 65536. In mode 0 the output stays low for 65535 ticks and rises on tick 65536, when `count_o` reads 0.
- R3: Mode 0 (code 0): the output is low from the committing tick. It rises once the elapsed ticks d reach the initial count N, and stays high until a new count is committed.
- R4: Mode 1 (code 1): after commit the output is high and `count_o` holds N until a gate rising edge has been captured and a tick follows. From that tick the output is low while d < N and high once d reaches N.
- R5: Mode 2 (code 2): the output is high only when d mod N = 0 and d > 0, never at commit. `count_o` reads N − (d mod N).
- R6: Mode 3 (code 3): the output is high while (d mod N) < (N+1)/2, using integer division, and low otherwise, so an odd N gives the longer half high. `count_o` reads N − (2d mod N).
- R7: Modes 4 and 5 (codes 4, 5): the output is high only while d = N, a single tick, and the pulse does not repeat.
- R8: In modes 1, 2, 3 and 5, a gate rising edge is captured. At the next tick d restarts at 0 from the initial count.
- R9: In modes 0, 2, 3 and 4, a low gate (as seen on `gate_o`) stops d from advancing and keeps the current count. Modes 1 and 5 ignore the gate level.
- R10: In modes 0, 1, 4 and 5, `count_o` reads (N − d) mod 65536 and keeps falling past zero.
- R11: `load` only stages the mode and count. Without a tick, `count_o` and `out_o` do not change. The staged values take effect on the next tick, which sets d to 0.
- R12: Mode codes 6 and 7 behave as codes 2 and 3.
- R13: `gate_o` equals the `gate` input delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count enable |
| gate | input | 1 | Gate level |
| load | input | 1 | Stage `mode_in` and `count_in` |
| mode_in | input | 3 | Mode code 0..7 |
| count_in | input | CW | Initial count, 0 means 2^CW |
| count_o | output | CW | Live count value |
| out_o | output | 1 | Channel output |
| gate_o | output | 1 | Registered gate level |

## Verification
Most faults in the elapsed-tick register or the staged count show up on `count_o` at the first tick after the fault, because every tick moves the readable value by one or two. A wrong period wrap in the repeating modes shows up on `out_o` within one period, as a misplaced pulse or a wrong high/low split. A stuck ARMED state or a lost gate edge leaves `out_o` high or the count frozen, and this is visible at the first tick after the gate edge.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_LOAD  = 2'd1,
        ST_ARMED = 2'd2
    } ictr_state_e;

    typedef enum logic [2:0] {
        MD_TERMINAL  = 3'd0,
        MD_ONESHOT   = 3'd1,
        MD_RATE      = 3'd2,
        MD_SQUARE    = 3'd3,
        MD_SW_STROBE = 3'd4,
        MD_HW_STROBE = 3'd5
    } ictr_mode_e;

    // codes 6 and 7 fold onto the two repeating modes
    function automatic ictr_mode_e norm_mode(input logic [2:0] code);
        if (code[2:1] == 2'b11) return ictr_mode_e'({1'b0, code[1:0]});
        return ictr_mode_e'(code);
    endfunction

    function automatic logic is_periodic(input ictr_mode_e m);
        return (m == MD_RATE) || (m == MD_SQUARE);
    endfunction

    function automatic logic edge_restarts(input ictr_mode_e m);
        return (m == MD_ONESHOT) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_HW_STROBE);
    endfunction

    function automatic logic level_holds(input ictr_mode_e m);
        return (m == MD_TERMINAL) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_SW_STROBE);
    endfunction

endpackage

// File: rtl/ictr_ctrl.sv
module ictr_ctrl
    import ictr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          gate,
    input  logic          load,
    input  logic [2:0]    mode_in,
    input  logic [CW-1:0] count_in,
    output ictr_mode_e    mode_q,
    output logic [CW:0]   init_q,
    output logic [CW:0]   go_val,
    output logic          go,
    output logic          step,
    output logic          armed,
    output logic          run,
    output logic          gate_q
);

    localparam logic [CW:0] FULL_COUNT = {1'b1, {CW{1'b0}}};

    ictr_state_e   state_q, state_d;
    ictr_mode_e    pend_mode_q;
    logic [CW-1:0] pend_cnt_q;
    logic [CW:0]   pend_init;
    logic          trig_q, rise, apply, restart, hold_hi_q;

    assign rise      = gate & ~gate_q;
    assign pend_init = (pend_cnt_q == '0) ? FULL_COUNT : {1'b0, pend_cnt_q};

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:  if (tick) state_d = (pend_mode_q == MD_ONESHOT) ? ST_ARMED : ST_RUN;
            ST_ARMED: if (tick && trig_q) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
        if (load) state_d = ST_LOAD;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // outputs of the machine
    always_comb begin
        apply   = 1'b0;
        restart = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            ST_LOAD:  apply   = tick && !load;
            ST_ARMED: restart = tick && trig_q;
            ST_RUN: begin
                restart = tick && trig_q && edge_restarts(mode_q);
                step    = tick && !restart && (gate_q || !level_holds(mode_q));
            end
            default: ;
        endcase
        go     = apply | restart;
        go_val = apply ? pend_init : init_q;
        armed  = hold_hi_q;
        run    = (state_q == ST_RUN);
    end

    // configuration and gate capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= MD_SQUARE;
            init_q      <= FULL_COUNT;
            pend_mode_q <= MD_SQUARE;
            pend_cnt_q  <= '0;
            gate_q      <= 1'b0;
            trig_q      <= 1'b0;
            hold_hi_q   <= 1'b0;
        end else begin
            gate_q <= gate;
            trig_q <= rise | (trig_q & ~tick);
            if (load) begin
                pend_mode_q <= norm_mode(mode_in);
                pend_cnt_q  <= count_in;
            end
            if (apply) begin
                mode_q    <= pend_mode_q;
                init_q    <= pend_init;
                hold_hi_q <= (pend_mode_q == MD_ONESHOT);
            end else if (restart) begin
                hold_hi_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ictr_datapath.sv
module ictr_datapath
    import ictr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ictr_mode_e    mode,
    input  logic [CW:0]   init,
    input  logic          go,
    input  logic [CW:0]   go_val,
    input  logic          step,
    input  logic          armed,
    output logic          out,
    output logic [CW-1:0] count
);

    logic [CW:0]   el_q;
    logic [CW-1:0] dn_q;
    logic          past_q;
    logic [CW+1:0] sum, dbl, fold;
    logic [CW:0]   half;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            el_q   <= '0;
            dn_q   <= '0;
            past_q <= 1'b0;
        end else if (go) begin
            el_q   <= '0;
            dn_q   <= go_val[CW-1:0];
            past_q <= 1'b0;
        end else if (step) begin
            if (is_periodic(mode)) begin
                el_q   <= (el_q == init - 1'b1) ? '0 : el_q + 1'b1;
                past_q <= 1'b1;
            end else begin
                if (el_q <= init) el_q <= el_q + 1'b1;
                dn_q <= dn_q - 1'b1;
            end
        end
    end

    assign sum  = {1'b0, init} + 1'b1;
    assign half = sum[CW+1:1];
    assign dbl  = {el_q, 1'b0};
    assign fold = (dbl >= {1'b0, init}) ? dbl - {1'b0, init} : dbl;

    always_comb begin
        out   = 1'b0;
        count = dn_q;
        unique case (mode)
            MD_TERMINAL: out = (el_q >= init);
            MD_ONESHOT:  out = armed | (el_q >= init);
            MD_RATE: begin
                out   = past_q && (el_q == '0);
                count = init[CW-1:0] - el_q[CW-1:0];
            end
            MD_SQUARE: begin
                out   = (el_q < half);
                count = init[CW-1:0] - fold[CW-1:0];
            end
            MD_SW_STROBE, MD_HW_STROBE: out = (el_q == init);
            default: ;
        endcase
    end

endmodule

// File: rtl/interval_counter_channel.sv
module interval_counter_channel
    import ictr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          gate,
    input  logic          load,
    input  logic [2:0]    mode_in,
    input  logic [CW-1:0] count_in,
    output logic [CW-1:0] count_o,
    output logic          out_o,
    output logic          gate_o
);

    ictr_mode_e  mode_q;
    logic [CW:0] init_q, go_val;
    logic        go, step, armed, st_run;

    ictr_ctrl #(.CW(CW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .gate     (gate),
        .load     (load),
        .mode_in  (mode_in),
        .count_in (count_in),
        .mode_q   (mode_q),
        .init_q   (init_q),
        .go_val   (go_val),
        .go       (go),
        .step     (step),
        .armed    (armed),
        .run      (st_run),
        .gate_q   (gate_o)
    );

    ictr_datapath #(.CW(CW)) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode_q),
        .init   (init_q),
        .go     (go),
        .go_val (go_val),
        .step   (step),
        .armed  (armed),
        .out    (out_o),
        .count  (count_o)
    );

endmodule

// File: rtl/ictr_checker.sv
module ictr_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          gate,
    input logic          out_o,
    input logic          gate_o,
    input logic          st_run,
    input logic [2:0]    mode_q,
    input logic [CW-1:0] count_o
);

    // R11: nothing visible moves without a tick
    a_r11_still_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(count_o) && $stable(out_o)));

    // R13: gate level appears one clock later
    a_r13_gate_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n)) |-> (gate_o == $past(gate)));

    // R3: terminal-count output stays high while running
    a_r3_sticky_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st_run && mode_q == 3'd0 && out_o) |=> out_o);

    // R7: strobe lasts a single tick
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (st_run && out_o && tick && (mode_q == 3'd5 || (mode_q == 3'd4 && gate_o))) |=> !out_o);

    // R12: stored mode is always a folded code
    a_r12_mode_folded: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q <= 3'd5);

endmodule

bind interval_counter_channel ictr_checker #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .gate    (gate),
    .out_o   (out_o),
    .gate_o  (gate_o),
    .st_run  (st_run),
    .mode_q  (mode_q),
    .count_o (count_o)
);

// File: tb/sim_interval_counter_channel.sv
module sim_interval_counter_channel;
    localparam int CW = 16;

    logic          clk = 1'b0, rst_n = 1'b0, tick = 1'b0, gate = 1'b1, load = 1'b0;
    logic [2:0]    mode_in = '0;
    logic [CW-1:0] count_in = '0;
    logic [CW-1:0] count_o;
    logic          out_o, gate_o;
    int            checks = 0, failures = 0;

    always #4 clk = ~clk;

    interval_counter_channel #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .load(load),
        .mode_in(mode_in), .count_in(count_in),
        .count_o(count_o), .out_o(out_o), .gate_o(gate_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic ticks(input int k);
        tick = 1'b1;
        repeat (k) cyc();
        tick = 1'b0;
    endtask

    task automatic do_load(input int m, input int n);
        load = 1'b1; mode_in = m[2:0]; count_in = n[CW-1:0]; tick = 1'b0;
        cyc();
        load = 1'b0; tick = 1'b1;
        cyc();
        tick = 1'b0;
    endtask

    task automatic gate_pulse_rise();
        gate = 1'b0; cyc();
        gate = 1'b1; cyc();
    endtask

    function automatic int fold(input int m);
        return (m >= 6) ? m - 4 : m;
    endfunction

    function automatic int exp_out(input int m, input int n, input int d);
        case (fold(m))
            0, 1: return (d >= n) ? 1 : 0;
            2: return ((d % n) == 0 && d != 0) ? 1 : 0;
            3: return ((d % n) < (n + 1) / 2) ? 1 : 0;
            default: return (d == n) ? 1 : 0;
        endcase
    endfunction

    function automatic int exp_cnt(input int m, input int n, input int d);
        case (fold(m))
            2: return (n - (d % n)) & 32'hFFFF;
            3: return (n - ((2 * d) % n)) & 32'hFFFF;
            default: return (n - d) & 32'hFFFF;
        endcase
    endfunction

    function automatic string tag(input int m, input int n, input int d);
        if (m >= 6) return "R12";
        if (m != 2 && m != 3 && d > n) return "R10";
        case (m)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        chk("R1", "reset count", count_o, 0);
        chk("R1", "reset out", out_o, 1);
        chk("R13", "gate_o after reset", gate_o, 1);
        // first tick consumes the gate edge seen at reset release, second advances
        ticks(2);
        chk("R1", "count after two ticks", count_o, 65534);
        chk("R1", "out after two ticks", out_o, 1);

        // sweep every mode code over small counts
        for (int m = 0; m < 8; m++) begin
            for (int n = 1; n <= 8; n++) begin
                do_load(m, n);
                if (m == 1) begin
                    chk("R4", "armed out", out_o, 1);
                    chk("R4", "armed count", count_o, n);
                    ticks(2);
                    chk("R4", "armed ignores ticks", count_o, n);
                    gate_pulse_rise();
                    ticks(1);
                end
                chk(tag(m, n, 0), "out d=0", out_o, exp_out(m, n, 0));
                chk(tag(m, n, 0), "count d=0", count_o, exp_cnt(m, n, 0));
                for (int d = 1; d <= n + 3; d++) begin
                    ticks(1);
                    chk(tag(m, n, d), "out", out_o, exp_out(m, n, d));
                    chk(tag(m, n, d), "count", count_o, exp_cnt(m, n, d));
                end
            end
        end

        // R9: low gate freezes mode 0
        do_load(0, 10);
        ticks(3);
        gate = 1'b0; cyc();
        ticks(5);
        chk("R9", "mode0 frozen count", count_o, 7);
        chk("R9", "mode0 frozen out", out_o, 0);
        gate = 1'b1; cyc();
        ticks(1);
        chk("R9", "mode0 resumes", count_o, 6);

        // R9 and R8 in mode 3
        do_load(3, 6);
        ticks(2);
        gate = 1'b0; cyc();
        ticks(4);
        chk("R9", "mode3 frozen count", count_o, 2);
        chk("R9", "mode3 frozen out", out_o, 1);
        gate = 1'b1; cyc();
        ticks(1);
        chk("R8", "mode3 restart count", count_o, 6);
        ticks(3);
        chk("R8", "mode3 second half out", out_o, 0);
        chk("R8", "mode3 second half count", count_o, 6);

        // R8 in mode 5, gate level ignored
        do_load(5, 4);
        ticks(2);
        chk("R9", "mode5 counts", count_o, 2);
        gate_pulse_rise();
        ticks(1);
        chk("R8", "mode5 restart count", count_o, 4);
        chk("R8", "mode5 restart out", out_o, 0);
        ticks(4);
        chk("R8", "mode5 strobe", out_o, 1);
        ticks(1);
        chk("R7", "mode5 strobe ends", out_o, 0);

        // R8 in mode 2
        do_load(2, 5);
        ticks(3);
        gate_pulse_rise();
        ticks(1);
        chk("R8", "mode2 restart count", count_o, 5);
        ticks(5);
        chk("R8", "mode2 pulse after restart", out_o, 1);

        // R11: staged load waits for tick
        do_load(2, 5);
        ticks(3);
        load = 1'b1; mode_in = 3'd0; count_in = 16'd7;
        cyc();
        load = 1'b0;
        cyc();
        chk("R11", "staged count ignored", count_o, 2);
        chk("R11", "staged out ignored", out_o, 0);
        ticks(1);
        chk("R11", "commit count", count_o, 7);
        ticks(7);
        chk("R11", "commit mode0 out", out_o, 1);

        // R13: gate delay
        gate = 1'b0; cyc();
        chk("R13", "gate_o low", gate_o, 0);
        gate = 1'b1; cyc();
        chk("R13", "gate_o high", gate_o, 1);

        // R2: zero count is full range
        do_load(0, 0);
        chk("R2", "full count start", count_o, 0);
        ticks(65535);
        chk("R2", "before terminal out", out_o, 0);
        chk("R2", "before terminal count", count_o, 1);
        ticks(1);
        chk("R2", "terminal out", out_o, 1);
        chk("R2", "terminal count", count_o, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule